// File: doc/BRIEF.md
# Compressed-Audio Burst Preamble Detector

This block sits behind a digital audio receiver and inspects one audio word per received sub-frame. From each 24-bit sample it takes the upper 16 bits. It searches that word stream for the sync pattern that opens a compressed (non-PCM) burst: a run of at least four all-zero words, then 0xF872, then 0x4E1F. When the pattern completes, the block raises a burst-active flag. It then takes the next two valid words as the burst-info word and the length word. It publishes both words together, along with the data-type field and the payload-error bit decoded from the info word.

The flag is held by a frame-based timeout. A separate once-per-frame tick advances a counter while the flag is high. If 4096 ticks arrive without a further sync match, the flag drops. Each match restarts the count from zero. Downstream logic uses the flag to mute or reroute PCM processing, and uses the type field to pick a decoder.

The search is a small state machine. **ST_HUNT** waits for a zero word. **ST_ZRUN** counts zero words up to four and stays there while more zeros arrive. **ST_GOT_A** is entered when 0xF872 follows a full zero run. **ST_GET_INFO** is entered on 0x4E1F; this transition is the match. **ST_GET_LEN** takes the length word and returns to ST_HUNT. Three other transitions exist: a zero word in ST_GOT_A goes back to ST_ZRUN with a run of one, and any other wrong word in ST_ZRUN or ST_GOT_A goes back to ST_HUNT. A cycle with the valid strobe low leaves the state unchanged.

Top module: `burst_sync_detect`

## Requirements
- R1: After reset, burst_active_o, burst_info_o, burst_len_o, burst_type_o and burst_err_o are all zero, and they stay zero until a burst is captured.
- R2: The compared word is sample_i[23:8], and bits [7:0] of the sample are ignored. After valid words 0x0000 ×4, 0xF872 and 0x4E1F, burst_active_o is 1 in the cycle after the edge that takes 0x4E1F.
- R3: A zero run longer than four words still matches. A run of three zeros followed by 0xF872 and 0x4E1F does not match.
- R4: A wrong word breaks a partial match and the search restarts. A zero word that breaks a match after 0xF872 counts as the first zero of a new run.
- R5: A cycle with sample_valid_i low does not advance, break or restart the search, whatever sample_i holds.
- R6: The two valid words after a match become burst_info_o and burst_len_o. Both update together in the cycle after the edge that takes the second word. These two words are not searched for sync.
- R7: burst_type_o equals burst_info_o[4:0], and burst_err_o equals burst_info_o[7].
- R8: While the flag is high, each frame_tick_i advances the hold count, and nothing else does. The flag falls in the cycle after the 4096th tick since the last match.
- R9: A match restarts the hold count from zero. If a match and a tick fall in the same cycle, the match wins and that tick is not counted.
- R10: Synchronous reset asserted in mid-run clears the flag, the count, the captured words and any partial match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_valid_i | input | 1 | A new sub-frame sample is present |
| sample_i | input | 24 | Received audio sample; upper 16 bits are searched |
| frame_tick_i | input | 1 | One pulse per stereo frame |
| burst_active_o | output | 1 | Compressed burst detected and within hold time |
| burst_info_o | output | 16 | Captured burst-info word |
| burst_len_o | output | 16 | Captured length word |
| burst_type_o | output | 5 | Data-type field of the info word |
| burst_err_o | output | 1 | Payload-error bit of the info word |

## Verification
The sync match and the frame tick that would end the hold period can fall in the same cycle. The bench arranges this directly. It sends zeros and 0xF872, then exactly 4095 ticks, then 0x4E1F together with a tick. The flag must stay high, and it must survive another 4095 ticks before falling on the next one, which shows that the colliding tick was not counted. Random traffic with frequent zero, 0xF872 and 0x4E1F words and random ticks provokes further collisions. All of these are judged against a bench model that keeps a history of the last six words.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ZRUN,
        ST_GOT_A,
        ST_GET_INFO,
        ST_GET_LEN
    } hunt_state_e;

endpackage

// File: rtl/bsd_hunt_fsm.sv
module bsd_hunt_fsm
    import bsd_pkg::*;
#(
    parameter int                WORD_W     = 16,
    parameter int                LEAD_ZEROS = 4,
    parameter logic [WORD_W-1:0] SYNC_A     = 16'hF872,
    parameter logic [WORD_W-1:0] SYNC_B     = 16'h4E1F
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              match_o,
    output logic              cap_info_o,
    output logic              cap_len_o,
    output hunt_state_e       state_o
);

    localparam int            ZW    = $clog2(LEAD_ZEROS + 1);
    localparam logic [ZW-1:0] ZFULL = ZW'(LEAD_ZEROS);
    localparam logic [ZW-1:0] ZONE  = ZW'(1);

    hunt_state_e   state_q, state_d;
    logic [ZW-1:0] zrun_q, zrun_d;
    logic          is_zero, is_a, is_b;

    assign is_zero = (word_i == '0);
    assign is_a    = (word_i == SYNC_A);
    assign is_b    = (word_i == SYNC_B);

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HUNT;
            zrun_q  <= '0;
        end else begin
            state_q <= state_d;
            zrun_q  <= zrun_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        zrun_d  = zrun_q;
        if (valid_i) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (is_zero) begin
                        state_d = ST_ZRUN;
                        zrun_d  = ZONE;
                    end
                end
                ST_ZRUN: begin
                    if (is_zero) begin
                        if (zrun_q != ZFULL) zrun_d = zrun_q + 1'b1;
                    end else if (is_a && (zrun_q == ZFULL)) begin
                        state_d = ST_GOT_A;
                        zrun_d  = '0;
                    end else begin
                        state_d = ST_HUNT;
                        zrun_d  = '0;
                    end
                end
                ST_GOT_A: begin
                    if (is_b) begin
                        state_d = ST_GET_INFO;
                    end else if (is_zero) begin
                        state_d = ST_ZRUN;
                        zrun_d  = ZONE;
                    end else begin
                        state_d = ST_HUNT;
                    end
                end
                ST_GET_INFO: state_d = ST_GET_LEN;
                ST_GET_LEN:  state_d = ST_HUNT;
                default: begin
                    state_d = ST_HUNT;
                    zrun_d  = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        match_o    = valid_i && (state_q == ST_GOT_A) && is_b;
        cap_info_o = valid_i && (state_q == ST_GET_INFO);
        cap_len_o  = valid_i && (state_q == ST_GET_LEN);
        state_o    = state_q;
    end

endmodule

// File: rtl/bsd_capture.sv
module bsd_capture #(
    parameter int WORD_W  = 16,
    parameter int TYPE_W  = 5,
    parameter int ERR_BIT = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cap_info_i,
    input  logic              cap_len_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] info_o,
    output logic [WORD_W-1:0] len_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              err_o
);

    logic [WORD_W-1:0] stage_q, info_q, len_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
            info_q  <= '0;
            len_q   <= '0;
        end else begin
            if (cap_info_i) stage_q <= word_i;
            if (cap_len_i) begin
                info_q <= stage_q;
                len_q  <= word_i;
            end
        end
    end

    always_comb begin
        info_o = info_q;
        len_o  = len_q;
        type_o = info_q[TYPE_W-1:0];
        err_o  = info_q[ERR_BIT];
    end

endmodule

// File: rtl/bsd_hold_timer.sv
module bsd_hold_timer #(
    parameter int HOLD_FRAMES = 4096,
    parameter int CNT_W       = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             match_i,
    input  logic             tick_i,
    output logic             active_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_FRAMES - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (match_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (tick_i && active_q) begin
            if (cnt_q == LAST) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign count_o  = cnt_q;

endmodule

// File: rtl/burst_sync_detect.sv
module burst_sync_detect
    import bsd_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int WORD_W      = 16,
    parameter int LEAD_ZEROS  = 4,
    parameter int HOLD_FRAMES = 4096,
    parameter int TYPE_W      = 5,
    parameter int ERR_BIT     = 7
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                sample_valid_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                frame_tick_i,
    output logic                burst_active_o,
    output logic [WORD_W-1:0]   burst_info_o,
    output logic [WORD_W-1:0]   burst_len_o,
    output logic [TYPE_W-1:0]   burst_type_o,
    output logic                burst_err_o
);

    localparam int CW    = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1;
    localparam int LOW_W = SAMPLE_W - WORD_W;

    logic [WORD_W-1:0] word;
    logic              unused_low;
    logic              sync_match, cap_info, cap_len;
    hunt_state_e       hunt_state;
    logic [CW-1:0]     hold_count;

    assign word       = sample_i[SAMPLE_W-1 -: WORD_W];
    assign unused_low = ^sample_i[LOW_W-1:0];

    bsd_hunt_fsm #(
        .WORD_W    (WORD_W),
        .LEAD_ZEROS(LEAD_ZEROS)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .valid_i   (sample_valid_i),
        .word_i    (word),
        .match_o   (sync_match),
        .cap_info_o(cap_info),
        .cap_len_o (cap_len),
        .state_o   (hunt_state)
    );

    bsd_capture #(
        .WORD_W (WORD_W),
        .TYPE_W (TYPE_W),
        .ERR_BIT(ERR_BIT)
    ) u_cap (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cap_info_i(cap_info),
        .cap_len_i (cap_len),
        .word_i    (word),
        .info_o    (burst_info_o),
        .len_o     (burst_len_o),
        .type_o    (burst_type_o),
        .err_o     (burst_err_o)
    );

    bsd_hold_timer #(
        .HOLD_FRAMES(HOLD_FRAMES),
        .CNT_W      (CW)
    ) u_hold (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .match_i (sync_match),
        .tick_i  (frame_tick_i),
        .active_o(burst_active_o),
        .count_o (hold_count)
    );

endmodule

// File: rtl/bsd_detect_chk.sv
module bsd_detect_chk
    import bsd_pkg::*;
#(
    parameter int HOLD_FRAMES = 4096,
    parameter int CNT_W       = 12,
    parameter int WORD_W      = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              valid_i,
    input logic              tick_i,
    input logic              match_i,
    input logic              cap_len_i,
    input hunt_state_e       state_i,
    input logic              active_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [WORD_W-1:0] info_i,
    input logic [WORD_W-1:0] len_i
);

    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!active_i && info_i == '0 && len_i == '0 && cnt_i == '0));

    // R2
    match_sets_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        match_i |=> active_i);

    // R5
    idle_holds_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(state_i));

    // R6
    info_on_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(info_i) |-> $past(cap_len_i));

    // R6
    len_on_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(len_i) |-> $past(cap_len_i));

    // R8
    fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(active_i) |-> ($past(tick_i) && !$past(match_i)));

    // R8
    count_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        32'(cnt_i) < HOLD_FRAMES);

    // R9
    match_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        match_i |=> (cnt_i == '0));

endmodule

bind burst_sync_detect bsd_detect_chk #(
    .HOLD_FRAMES(HOLD_FRAMES),
    .CNT_W      (CW),
    .WORD_W     (WORD_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .valid_i  (sample_valid_i),
    .tick_i   (frame_tick_i),
    .match_i  (sync_match),
    .cap_len_i(cap_len),
    .state_i  (hunt_state),
    .active_i (burst_active_o),
    .cnt_i    (hold_count),
    .info_i   (burst_info_o),
    .len_i    (burst_len_o)
);

// File: tb/tb_burst_sync_detect.sv
module tb_burst_sync_detect;

    localparam logic [15:0] SA = 16'hF872;
    localparam logic [15:0] SB = 16'h4E1F;
    localparam int HOLD = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [23:0] sample = '0;
    logic        tick = 1'b0;
    logic        active;
    logic [15:0] info, len;
    logic [4:0]  btype;
    logic        berr;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // reference model state
    logic [15:0] hist [6];
    int          hcount = 0;
    int          skip   = 0;
    logic [15:0] m_stage = '0, m_info = '0, m_len = '0;
    logic        m_active = 1'b0;
    int          m_cnt = 0;

    always #4 clk = ~clk;

    burst_sync_detect dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .sample_valid_i(valid),
        .sample_i      (sample),
        .frame_tick_i  (tick),
        .burst_active_o(active),
        .burst_info_o  (info),
        .burst_len_o   (len),
        .burst_type_o  (btype),
        .burst_err_o   (berr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic hist_is_sync();
        return hist[0] == SB && hist[1] == SA && hist[2] == 16'h0 &&
               hist[3] == 16'h0 && hist[4] == 16'h0 && hist[5] == 16'h0;
    endfunction

    task automatic model_reset();
        hcount = 0; skip = 0;
        m_stage = '0; m_info = '0; m_len = '0;
        m_active = 1'b0; m_cnt = 0;
        for (int k = 0; k < 6; k++) hist[k] = '1;
    endtask

    task automatic model_edge(input logic v, input logic [15:0] w, input logic t);
        logic m;
        m = 1'b0;
        if (v) begin
            if (skip == 2) begin
                m_stage = w; skip = 1;
            end else if (skip == 1) begin
                m_info = m_stage; m_len = w; skip = 0; hcount = 0;
            end else begin
                for (int k = 5; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = w;
                if (hcount < 6) hcount++;
                if (hcount >= 6 && hist_is_sync()) begin
                    m = 1'b1; skip = 2; hcount = 0;
                end
            end
        end
        if (m) begin
            m_active = 1'b1; m_cnt = 0;
        end else if (t && m_active) begin
            if (m_cnt == HOLD - 1) begin
                m_active = 1'b0; m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic compare_model();
        check("R8 flag vs model", {31'd0, active}, {31'd0, m_active});
        check("R6 info vs model", {16'd0, info}, {16'd0, m_info});
        check("R6 len vs model", {16'd0, len}, {16'd0, m_len});
        check("R7 type vs model", {27'd0, btype}, {27'd0, m_info[4:0]});
        check("R7 err vs model", {31'd0, berr}, {31'd0, m_info[7]});
    endtask

    // drive one cycle; compare 2 ns after the edge
    task automatic step(input logic v, input logic [15:0] w, input logic t);
        valid  = v;
        sample = {w, 8'($urandom)};
        tick   = t;
        @(posedge clk);
        model_edge(v, w, t);
        #2;
        compare_model();
    endtask

    task automatic apply_reset();
        rst = 1'b1; valid = 1'b0; tick = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        model_reset();
    endtask

    task automatic send_sync(input int zeros);
        for (int k = 0; k < zeros; k++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, SA, 1'b0);
        step(1'b1, SB, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hB5E7));
        model_reset();
        apply_reset();

        // R1 reset state
        check("R1 flag", {31'd0, active}, 32'd0);
        check("R1 info", {16'd0, info}, 32'd0);
        check("R1 len", {16'd0, len}, 32'd0);
        check("R1 type/err", {26'd0, berr, btype}, 32'd0);

        // R2 basic match, low byte random
        send_sync(4);
        check("R2 flag after sync", {31'd0, active}, 32'd1);
        check("R1 info still zero before capture", {16'd0, info}, 32'd0);
        // R6 R7 capture: type 11, error bit set
        step(1'b1, 16'h008B, 1'b0);
        check("R6 info not yet published", {16'd0, info}, 32'd0);
        step(1'b1, 16'h1800, 1'b0);
        check("R6 info", {16'd0, info}, 32'h008B);
        check("R6 len", {16'd0, len}, 32'h1800);
        check("R7 type", {27'd0, btype}, 32'd11);
        check("R7 err", {31'd0, berr}, 32'd1);

        // R3 short run fails, long run matches
        apply_reset();
        send_sync(3);
        check("R3 three zeros no match", {31'd0, active}, 32'd0);
        send_sync(7);
        check("R3 seven zeros match", {31'd0, active}, 32'd1);

        // R4 wrong word breaks; zero after 0xF872 restarts run
        apply_reset();
        for (int k = 0; k < 4; k++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'h1234, 1'b0);
        step(1'b1, SA, 1'b0);
        step(1'b1, SB, 1'b0);
        check("R4 broken run no match", {31'd0, active}, 32'd0);
        for (int k = 0; k < 4; k++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, SA, 1'b0);
        send_sync(4);
        check("R4 restart after zero break", {31'd0, active}, 32'd1);

        // R5 invalid cycles ignored
        apply_reset();
        for (int k = 0; k < 4; k++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, SA, 1'b0);
        step(1'b0, 16'h5555, 1'b0);
        step(1'b0, 16'h0000, 1'b0);
        step(1'b1, SB, 1'b0);
        check("R5 gaps do not break match", {31'd0, active}, 32'd1);
        step(1'b0, 16'hAAAA, 1'b0);
        step(1'b1, 16'h0001, 1'b0);
        step(1'b0, 16'hBBBB, 1'b0);
        step(1'b1, 16'h0200, 1'b0);
        check("R5 gap words not captured", {16'd0, info}, 32'h0001);
        check("R6 len after gaps", {16'd0, len}, 32'h0200);

        // R6 capture words not searched
        apply_reset();
        send_sync(4);
        step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'h0000, 1'b0);
        step(1'b1, SA, 1'b0);
        step(1'b1, SB, 1'b0);
        step(1'b1, 16'h0003, 1'b0);
        step(1'b1, 16'h0044, 1'b0);
        check("R6 capture zeros not counted", {16'd0, info}, 32'h0000);

        // R8 timeout exact
        apply_reset();
        send_sync(4);
        for (int k = 0; k < 50; k++) step(1'b1, 16'h1111, 1'b0);
        for (int k = 0; k < HOLD - 1; k++) step(1'b0, 16'h0000, 1'b1);
        check("R8 held after 4095 ticks", {31'd0, active}, 32'd1);
        step(1'b0, 16'h0000, 1'b1);
        check("R8 cleared on 4096th tick", {31'd0, active}, 32'd0);

        // R9 match collides with final tick
        apply_reset();
        send_sync(4);
        step(1'b1, 16'h0001, 1'b0);
        step(1'b1, 16'h0010, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, SA, 1'b0);
        for (int k = 0; k < HOLD - 1; k++) step(1'b0, 16'h0000, 1'b1);
        step(1'b1, SB, 1'b1);
        check("R9 match beats last tick", {31'd0, active}, 32'd1);
        for (int k = 0; k < HOLD - 1; k++) step(1'b0, 16'h0000, 1'b1);
        check("R9 colliding tick not counted", {31'd0, active}, 32'd1);
        step(1'b0, 16'h0000, 1'b1);
        check("R9 clears after full restart", {31'd0, active}, 32'd0);

        // R10 reset mid-run
        send_sync(4);
        step(1'b1, 16'h0004, 1'b0);
        step(1'b1, 16'h0800, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, SA, 1'b0);
        apply_reset();
        step(1'b1, SB, 1'b0);
        check("R10 partial match lost", {31'd0, active}, 32'd0);
        check("R10 captured words cleared", {16'd0, info}, 32'd0);

        // constrained random traffic
        apply_reset();
        begin
            int pos;
            pos = -1;
            for (int i = 0; i < 40000; i++) begin
                logic        v, t;
                logic [15:0] w;
                int          r;
                if (pos < 0 && i < 15000 && ($urandom % 40) == 0) pos = 0;
                t = (($urandom % 3) == 0);
                if (pos >= 0) begin
                    v = 1'b1;
                    if (pos < 4) w = 16'h0000;
                    else if (pos == 4) w = SA;
                    else if (pos == 5) w = SB;
                    else w = 16'($urandom);
                    pos = (pos == 7) ? -1 : pos + 1;
                end else begin
                    v = (($urandom % 5) != 0);
                    r = $urandom % 8;
                    if (r < 3) w = 16'h0000;
                    else if (r == 3) w = SA;
                    else if (r == 4) w = SB;
                    else w = 16'($urandom);
                end
                step(v, w, t);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule